// File: doc/BRIEF.md
# APB Register Target with Error Flag

This block is an APB3 subordinate holding a sixteen-byte register window. It contains four 32-bit word registers. Three of them can be read and written. One is a read-only status word that returns a fixed value. Every offset above the window is unmapped. The number of wait states is set at build time, so PREADY can stay low for a chosen number of access cycles before the transfer completes.

Illegal accesses are reported on PSLVERR. Four conditions count as illegal, and any of them raises the same single bit:
- an offset outside the window;
- a write to the status word;
- a non-secure access to the guarded word;
- an internal parity fault injected from outside.

The flag only qualifies the result of the access. A failed access completes on the same cycle a good one would. Its write is dropped, a failed read returns zero, and no retry is requested. A parameter can turn error reporting off, which ties PSLVERR low.

Top module: `apb_regfile_sub`

## Requirements
- R1: While reset is asserted and after it, PREADY and PSLVERR are low. The three writable words read back as zero, and the status word reads STATUS_WORD.
- R2: In an access phase (PSEL and PENABLE high), PREADY stays low for exactly WAIT_CYCLES cycles and is then high for one cycle. This holds whether the access passes or fails. PREADY is never high outside an access phase.
- R3: PSLVERR is high only in a cycle where PSEL, PENABLE and PREADY are all high. It is low in the setup cycle and in every wait cycle, even when a fault condition is present then.
- R4: An access whose byte offset is greater than 0x0F completes with PSLVERR high.
- R5: A write to offsets 0x04 to 0x07 (the status word) completes with PSLVERR high. A read of it returns STATUS_WORD with PSLVERR low.
- R6: An access with PPROT[1]=1 to offsets 0x08 to 0x0B (the guarded word) is a protection violation and completes with PSLVERR high. This applies to reads as well as writes.
- R7: If par_fault is high in the completion cycle, the access completes with PSLVERR high. A par_fault pulse that is present only in the setup or wait cycles causes no error.
- R8: A write that fails any check leaves every register unchanged. A read that fails returns PRDATA = 0. PRDATA is also 0 whenever no read is completing.
- R9: Offsets 0x00, 0x08 and 0x0C each hold a writable 32-bit word. Within the window, PADDR[3:2] selects the word and PADDR[1:0] is ignored. A read returns the last successful write.
- R10: With ERR_EN = 0, PSLVERR stays low for every access, including the illegal ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Subordinate selected |
| penable | input | 1 | Access phase of the transfer |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte offset of the access |
| pwdata | input | DATA_W | Write data |
| pprot | input | 3 | Protection attributes; bit 1 set means non-secure |
| par_fault | input | 1 | Injected internal parity fault, sampled at completion |
| prdata | output | DATA_W | Read data, valid when a read completes |
| pready | output | 1 | Transfer completes in this access cycle |
| pslverr | output | 1 | The completing transfer failed |

## Verification
The bench builds two copies of the block that share one bus.
- The first copy uses WAIT_CYCLES = 2 and ERR_EN = 1. With two wait cycles, the bench can show that the error flag stays low through a stretched access. This holds even when par_fault pulses during the setup and wait cycles and then drops before completion.
- The second copy uses WAIT_CYCLES = 0 and ERR_EN = 1'b0. With it, the bench can show that the flag stays tied low while the illegal accesses aimed at the first copy are on the bus.

Random offsets run slightly past the window, so unmapped, read-only, guarded and good accesses are mixed with random PPROT and fault bits.

// File: rtl/apb_sub_pkg.sv
package apb_sub_pkg;

    // Word index of the read-only status word (offset 0x04)
    localparam int STATUS_IDX = 1;
    // Word index of the word guarded against non-secure access (offset 0x08)
    localparam int SECURE_IDX = 2;
    // Bytes in the mapped window
    localparam int MAP_BYTES  = 16;

    typedef struct packed {
        logic out_of_map;
        logic ro_write;
        logic prot_fail;
        logic par_fail;
    } err_cause_t;

endpackage

// File: rtl/apb_wait_ctrl.sv
module apb_wait_ctrl #(
    parameter int WAIT_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    output logic ready
);

    generate
        if (WAIT_CYCLES == 0) begin : g_nowait
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign ready      = access;
        end else begin : g_wait
            localparam int CNT_W = $clog2(WAIT_CYCLES + 1);

            typedef struct packed {
                logic [CNT_W-1:0] cnt;
            } wait_st_t;

            wait_st_t st_d, st_q;

            assign ready = access && (st_q.cnt == CNT_W'(WAIT_CYCLES));

            always_comb begin
                st_d = st_q;
                if (!access || ready) begin
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/apb_access_check.sv
module apb_access_check
    import apb_sub_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 2
) (
    input  logic [ADDR_W-1:0] paddr,
    input  logic              pwrite,
    input  logic              nonsecure,
    input  logic              par_fault,
    output logic [IDX_W-1:0]  idx,
    output err_cause_t        cause,
    output logic              any_err
);

    always_comb begin
        idx              = paddr[OFF_W-1:2];
        cause.out_of_map = |paddr[ADDR_W-1:OFF_W];
        cause.ro_write   = !cause.out_of_map && pwrite
                           && (idx == IDX_W'(STATUS_IDX));
        cause.prot_fail  = !cause.out_of_map && nonsecure
                           && (idx == IDX_W'(SECURE_IDX));
        cause.par_fail   = par_fault;
        any_err          = |cause;
    end

endmodule

// File: rtl/apb_reg_store.sv
module apb_reg_store
    import apb_sub_pkg::*;
#(
    parameter int              DATA_W      = 32,
    parameter int              NUM_REGS    = 4,
    parameter int              IDX_W       = 2,
    parameter logic [DATA_W-1:0] STATUS_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (idx != IDX_W'(STATUS_IDX))) begin
            st_d.regs[idx] = wdata;
        end
    end

    always_comb begin
        if (idx == IDX_W'(STATUS_IDX)) begin
            rdata = STATUS_WORD;
        end else begin
            rdata = st_q.regs[idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/apb_regfile_sub.sv
module apb_regfile_sub
    import apb_sub_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 32,
    parameter int                WAIT_CYCLES = 1,
    parameter bit                ERR_EN      = 1'b1,
    parameter logic [DATA_W-1:0] STATUS_WORD = 32'hA5C3_0001
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [2:0]        pprot,
    input  logic              par_fault,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr
);

    localparam int OFF_W    = $clog2(MAP_BYTES);
    localparam int NUM_REGS = MAP_BYTES / 4;
    localparam int IDX_W    = $clog2(NUM_REGS);

    logic              access;
    logic              done;
    logic              any_err;
    logic              commit_wr;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rdata;
    err_cause_t        cause;
    logic              unused_bits;

    assign access      = psel && penable;
    assign done        = access && pready;
    assign commit_wr   = done && pwrite && !any_err;
    assign unused_bits = ^{pprot[2], pprot[0], paddr[1:0], cause};

    apb_wait_ctrl #(
        .WAIT_CYCLES (WAIT_CYCLES)
    ) u_wait (
        .clk    (pclk),
        .rst_n  (presetn),
        .access (access),
        .ready  (pready)
    );

    apb_access_check #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W)
    ) u_check (
        .paddr     (paddr),
        .pwrite    (pwrite),
        .nonsecure (pprot[1]),
        .par_fault (par_fault),
        .idx       (idx),
        .cause     (cause),
        .any_err   (any_err)
    );

    apb_reg_store #(
        .DATA_W      (DATA_W),
        .NUM_REGS    (NUM_REGS),
        .IDX_W       (IDX_W),
        .STATUS_WORD (STATUS_WORD)
    ) u_store (
        .clk   (pclk),
        .rst_n (presetn),
        .wr_en (commit_wr),
        .idx   (idx),
        .wdata (pwdata),
        .rdata (rdata)
    );

    assign prdata = (done && !pwrite && !any_err) ? rdata : '0;

    generate
        if (ERR_EN) begin : g_err
            assign pslverr = done && any_err;
        end else begin : g_noerr
            assign pslverr = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/apb_regfile_sub_chk.sv
module apb_regfile_sub_chk #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int WAIT_CYCLES = 1,
    parameter bit ERR_EN      = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic              pready,
    input logic              pslverr,
    input logic [ADDR_W-1:0] paddr,
    input logic [DATA_W-1:0] prdata
);

    logic [3:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (psel && penable && !pready && lat_q != 4'hF) begin
            lat_q <= lat_q + 4'd1;
        end else if (!(psel && penable && !pready)) begin
            lat_q <= '0;
        end
    end

    // R3
    err_only_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (psel && penable && pready));

    // R2
    ready_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pready |-> (psel && penable));

    // R2
    wait_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pready) |-> (lat_q == 4'(WAIT_CYCLES)));

    // R8
    failed_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pslverr && !pwrite) |-> (prdata == '0));

    // R8
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pready && !pwrite) |-> (prdata == '0));

    // R4
    unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ERR_EN && psel && penable && pready && (paddr > ADDR_W'(15))) |-> pslverr);

    // R10
    err_tied_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ERR_EN == 1'b0) |-> !pslverr);

endmodule

bind apb_regfile_sub apb_regfile_sub_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .WAIT_CYCLES (WAIT_CYCLES),
    .ERR_EN      (ERR_EN)
) u_chk (
    .clk     (pclk),
    .rst_n   (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .pready  (pready),
    .pslverr (pslverr),
    .paddr   (paddr),
    .prdata  (prdata)
);

// File: tb/sim_apb_regfile_sub.sv
module sim_apb_regfile_sub;

    localparam int          CLK_PERIOD  = 10;
    localparam int          WAIT        = 2;
    localparam logic [31:0] STATUS_WORD = 32'hA5C3_0001;

    logic        pclk = 1'b0;
    logic        presetn;
    logic        psel, penable, pwrite, par_fault;
    logic [7:0]  paddr;
    logic [31:0] pwdata;
    logic [2:0]  pprot;
    logic [31:0] prdata, prdata1;
    logic        pready, pslverr, pready1, pslverr1;

    int checks = 0;
    int misses = 0;
    logic [31:0] mdl [4];

    always #(CLK_PERIOD/2) pclk = ~pclk;

    apb_regfile_sub #(
        .ADDR_W(8), .DATA_W(32), .WAIT_CYCLES(WAIT), .ERR_EN(1'b1),
        .STATUS_WORD(STATUS_WORD)
    ) u0 (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pprot(pprot),
        .par_fault(par_fault), .prdata(prdata), .pready(pready), .pslverr(pslverr)
    );

    apb_regfile_sub #(
        .ADDR_W(8), .DATA_W(32), .WAIT_CYCLES(0), .ERR_EN(1'b0),
        .STATUS_WORD(STATUS_WORD)
    ) u1 (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pprot(pprot),
        .par_fault(par_fault), .prdata(prdata1), .pready(pready1), .pslverr(pslverr1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        chk(req, {31'b0, act}, {31'b0, exp});
    endtask

    function automatic logic exp_err(input logic [7:0] a, input logic w,
                                     input logic [2:0] pr, input logic f);
        logic in_map = (a <= 8'h0F);
        return !in_map || (w && a[3:2] == 2'd1) || (pr[1] && a[3:2] == 2'd2) || f;
    endfunction

    function automatic string tag_of(input logic [7:0] a, input logic w,
                                     input logic [2:0] pr, input logic f);
        if (a > 8'h0F)                 return "R4 unmapped";
        if (w && a[3:2] == 2'd1)       return "R5 status write";
        if (pr[1] && a[3:2] == 2'd2)   return "R6 protection";
        if (f)                         return "R7 parity";
        return "R9 good access";
    endfunction

    task automatic xfer(input logic [7:0] a, input logic w, input logic [31:0] d,
                        input logic [2:0] pr, input logic f_early, input logic f_done);
        logic        e;
        logic [31:0] expd;
        int          idx;
        string       tag;
        idx  = int'(a[3:2]);
        e    = exp_err(a, w, pr, f_done);
        tag  = tag_of(a, w, pr, f_done);
        expd = (!w && !e) ? ((idx == 1) ? STATUS_WORD : mdl[idx]) : 32'h0;
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; paddr = a; pwrite = w; pwdata = d;
        pprot = pr; par_fault = f_early;
        #1;
        chk1("R3 setup pslverr", pslverr, 1'b0);
        chk1("R2 setup pready", pready, 1'b0);
        @(negedge pclk);
        penable = 1'b1;
        for (int k = 0; k < WAIT; k++) begin
            #1;
            chk1("R2 wait pready", pready, 1'b0);
            chk1("R3 wait pslverr", pslverr, 1'b0);
            @(negedge pclk);
        end
        par_fault = f_done;
        #1;
        chk1("R2 completion pready", pready, 1'b1);
        chk1({tag, " pslverr"}, pslverr, e);
        chk1("R10 disabled pslverr", pslverr1, 1'b0);
        if (!w) chk({tag, " R8 prdata"}, prdata, expd);
        if (w && !e && idx != 1) mdl[idx] = d;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; par_fault = 1'b0;
        #1;
        chk1("R2 idle pready", pready, 1'b0);
        chk("R8 idle prdata", prdata, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        misses++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) mdl[i] = 32'h0;
        presetn = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        paddr = '0; pwdata = '0; pprot = '0; par_fault = 1'b0;
        repeat (3) @(negedge pclk);
        #1;
        chk1("R1 reset pready", pready, 1'b0);
        chk1("R1 reset pslverr", pslverr, 1'b0);
        presetn = 1'b1;

        // R1: reset contents
        xfer(8'h00, 1'b0, 0, 3'b000, 1'b0, 1'b0);
        xfer(8'h04, 1'b0, 0, 3'b000, 1'b0, 1'b0);
        xfer(8'h08, 1'b0, 0, 3'b000, 1'b0, 1'b0);
        xfer(8'h0C, 1'b0, 0, 3'b000, 1'b0, 1'b0);
        // R9: writes and readback, low offset bits ignored
        xfer(8'h00, 1'b1, 32'h1111_2222, 3'b000, 1'b0, 1'b0);
        xfer(8'h03, 1'b0, 0, 3'b000, 1'b0, 1'b0);
        xfer(8'h0E, 1'b1, 32'hCAFE_0C0C, 3'b000, 1'b0, 1'b0);
        xfer(8'h0C, 1'b0, 0, 3'b000, 1'b0, 1'b0);
        xfer(8'h08, 1'b1, 32'h0808_5EC0, 3'b000, 1'b0, 1'b0);
        // R5: status write rejected, status unchanged
        xfer(8'h04, 1'b1, 32'hDEAD_BEEF, 3'b000, 1'b0, 1'b0);
        xfer(8'h05, 1'b0, 0, 3'b000, 1'b0, 1'b0);
        // R4: unmapped read and write
        xfer(8'h10, 1'b1, 32'h0BAD_0BAD, 3'b000, 1'b0, 1'b0);
        xfer(8'hFF, 1'b0, 0, 3'b000, 1'b0, 1'b0);
        // R6: non-secure write and read of guarded word
        xfer(8'h08, 1'b1, 32'h7777_7777, 3'b010, 1'b0, 1'b0);
        xfer(8'h09, 1'b0, 0, 3'b010, 1'b0, 1'b0);
        xfer(8'h08, 1'b0, 0, 3'b101, 1'b0, 1'b0);
        // R7: fault at completion blocks write; early-only fault ignored
        xfer(8'h00, 1'b1, 32'h9999_0000, 3'b000, 1'b1, 1'b1);
        xfer(8'h00, 1'b0, 0, 3'b000, 1'b1, 1'b0);
        xfer(8'h0C, 1'b0, 0, 3'b000, 1'b0, 1'b1);
        // R8: read back after every blocked write
        xfer(8'h08, 1'b0, 0, 3'b000, 1'b0, 1'b0);

        for (int n = 0; n < 400; n++) begin
            logic [7:0] a;
            a = 8'($urandom_range(0, 23));
            xfer(a, 1'($urandom_range(0, 1)), $urandom(), 3'($urandom_range(0, 7)),
                 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 7) == 0));
        end
        for (int i = 0; i < 4; i++) xfer(8'(i * 4), 1'b0, 0, 3'b000, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
        $finish;
    end

endmodule